// File: doc/BRIEF.md
# Dual-Thread Interrupt Controller with Shadow Masking

This block gathers forty level-sensitive interrupt lines and turns them into two registered request outputs, one for each hardware thread of a two-thread processor. Software controls the block over a small 32-bit register bus. It can enable or disable each line through two mask registers, and it reads which lines are currently active through two pending registers.

Most lines go to exactly one thread. Parameter `ROUTE_VPE1` picks that thread. A few lines are per-CPU and may need to reach either thread. Each of these primary lines is paired with a second interrupt number, called its shadow. The primary's mask bit enables delivery to thread 0, and the shadow's mask bit enables delivery of the same primary line to thread 1. A shadow number is not a source of its own, so its input wire is never looked at.

The pairing comes from two parameter arrays. An elaboration check rejects the build in any of these cases:
- more than twenty pairs,
- a number outside 0..39,
- a line paired with itself,
- any number used twice.

Top module: `dvpe_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both mask registers, all pending bits, both request outputs and the read data.
- R2: The low mask register is at offset 0x04, with bit n enabling source n for n in 0..31. The high mask register is at offset 0x50 and holds sources 32..39 in bits 7:0; its bits 31:8 read as zero. A 1 enables a source and a 0 masks it. Full-word writes are read back.
- R3: The low pending register is at offset 0x08 (sources 0..31, bit n = source n). The high pending register is at offset 0x54 (sources 32..39 in bits 7:0). For an ordinary or primary number, a pending bit is that line's input level AND its own mask bit. For a shadow number, the pending bit is its primary's input level AND the shadow's mask bit. Writes to the pending offsets change nothing.
- R4: An ordinary source whose `ROUTE_VPE1` bit is 0 raises only `irq_vpe0`. An ordinary source whose bit is 1 raises only `irq_vpe1`. With the default parameters, sources 9, 10, 11, 16, 38 and 39 go to thread 1.
- R5: The mask bit of a primary number enables delivery of that primary line to thread 0 only. The default pairs are primary 8 with shadow 3, and primary 30 with shadow 29.
- R6: The mask bit of a shadow number enables delivery of its primary's line to thread 1 only. With both bits set, both requests are raised.
- R7: The input wire of a shadow number has no effect on any pending bit or request output.
- R8: Reads from any offset other than 0x04, 0x08, 0x50 and 0x54 return zero. Writes to those other offsets leave the masks unchanged.
- R9: Timing rules:
  - An input level present before clock edge k appears in pending and the requests at edge k.
  - A mask write sampled at edge k affects pending and the requests from edge k+1.
  - Read data sampled with the address at edge k is valid after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 40 | Level-sensitive interrupt lines, bit n = source n |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the offset sampled at the last edge |
| irq_vpe0 | output | 1 | Registered interrupt request to thread 0 |
| irq_vpe1 | output | 1 | Registered interrupt request to thread 1 |

## Verification
The bench uses three latencies:
- **Input change:** one edge. A change on an input line is visible on the requests after the next rising edge.
- **Mask write:** two edges. The write lands in the register at the first edge and is reflected in the requests at the second.
- **Register read:** one edge after the address is presented.

All stimulus is applied at the falling edge, and every value is sampled at a later falling edge counted from these rules. A dedicated step checks that a request is still low one edge after the enabling write and only rises at the next one.

// File: rtl/dvpe_irq_pkg.sv
package dvpe_irq_pkg;

    localparam int unsigned SRC_COUNT = 40;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned LO_COUNT  = DATA_W;
    localparam int unsigned HI_COUNT  = SRC_COUNT - LO_COUNT;
    localparam int unsigned MAX_PAIRS = SRC_COUNT / 2;

    typedef logic [SRC_COUNT-1:0] src_vec_t;
    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [DATA_W-1:0]    word_t;

    typedef enum logic [1:0] {
        ROLE_PLAIN,
        ROLE_PRIMARY,
        ROLE_SHADOW
    } role_e;

    typedef role_e       role_tab_t [SRC_COUNT];
    typedef int unsigned idx_tab_t  [SRC_COUNT];

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_LO,
        SEL_MASK_HI,
        SEL_PEND_LO,
        SEL_PEND_HI
    } reg_sel_e;

    localparam addr_t OFS_MASK_LO = 8'h04;
    localparam addr_t OFS_PEND_LO = 8'h08;
    localparam addr_t OFS_MASK_HI = 8'h50;
    localparam addr_t OFS_PEND_HI = 8'h54;

    typedef struct packed {
        logic vpe0;
        logic vpe1;
    } req_t;

    function automatic reg_sel_e decode_addr(input addr_t a);
        case (a)
            OFS_MASK_LO: return SEL_MASK_LO;
            OFS_MASK_HI: return SEL_MASK_HI;
            OFS_PEND_LO: return SEL_PEND_LO;
            OFS_PEND_HI: return SEL_PEND_HI;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dvpe_irq_regs.sv
module dvpe_irq_regs
    import dvpe_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  addr_t    reg_addr,
    input  logic     reg_wen,
    input  word_t    reg_wdata,
    input  src_vec_t pend,
    output src_vec_t mask,
    output word_t    reg_rdata
);

    logic [LO_COUNT-1:0] mask_lo_q;
    logic [HI_COUNT-1:0] mask_hi_q;
    word_t               rdata_q;
    word_t               rdata_d;
    reg_sel_e            sel;

    assign sel = decode_addr(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_lo_q <= '0;
            mask_hi_q <= '0;
        end else if (reg_wen) begin
            if (sel == SEL_MASK_LO) mask_lo_q <= reg_wdata[LO_COUNT-1:0];
            if (sel == SEL_MASK_HI) mask_hi_q <= reg_wdata[HI_COUNT-1:0];
        end
    end

    always_comb begin
        rdata_d = '0;
        case (sel)
            SEL_MASK_LO: rdata_d = mask_lo_q;
            SEL_MASK_HI: rdata_d[HI_COUNT-1:0] = mask_hi_q;
            SEL_PEND_LO: rdata_d = pend[LO_COUNT-1:0];
            SEL_PEND_HI: rdata_d[HI_COUNT-1:0] = pend[SRC_COUNT-1:LO_COUNT];
            default:     rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rdata_d;
    end

    assign mask      = {mask_hi_q, mask_lo_q};
    assign reg_rdata = rdata_q;

endmodule

// File: rtl/dvpe_irq_gate.sv
module dvpe_irq_gate
    import dvpe_irq_pkg::*;
#(
    parameter role_tab_t ROLES   = '{default: ROLE_PLAIN},
    parameter idx_tab_t  PARTNER = '{default: 0},
    parameter src_vec_t  SHD_SET = '0
)(
    input  src_vec_t irq_in,
    input  src_vec_t mask,
    output src_vec_t pend_next
);

    // Shadow wires are deliberately left out of the gating.
    logic unused_shadow_wires;
    assign unused_shadow_wires = ^(irq_in & SHD_SET);

    for (genvar n = 0; n < SRC_COUNT; n++) begin : g_src
        if (ROLES[n] == ROLE_SHADOW) begin : g_shadow
            assign pend_next[n] = irq_in[PARTNER[n]] & mask[n];
        end else begin : g_direct
            assign pend_next[n] = irq_in[n] & mask[n];
        end
    end

endmodule

// File: rtl/dvpe_irq_deliver.sv
module dvpe_irq_deliver
    import dvpe_irq_pkg::*;
#(
    parameter src_vec_t TO_VPE0 = '0,
    parameter src_vec_t TO_VPE1 = '0
)(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend_next,
    output src_vec_t pend_q,
    output req_t     req_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            req_q  <= '0;
        end else begin
            pend_q     <= pend_next;
            req_q.vpe0 <= |(pend_next & TO_VPE0);
            req_q.vpe1 <= |(pend_next & TO_VPE1);
        end
    end

endmodule

// File: rtl/dvpe_irq_ctrl.sv
module dvpe_irq_ctrl
    import dvpe_irq_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned PAIR_PRI [NUM_PAIRS] = '{8, 30},
    parameter int unsigned PAIR_SHD [NUM_PAIRS] = '{3, 29},
    parameter logic [39:0] ROUTE_VPE1 = 40'hC0_0001_0F00
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [39:0] irq_in,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wen,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_vpe0,
    output logic        irq_vpe1
);

    function automatic bit pairs_valid();
        src_vec_t seen;
        bit       ok;
        seen = '0;
        ok   = (NUM_PAIRS <= MAX_PAIRS);
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (PAIR_PRI[p] >= SRC_COUNT || PAIR_SHD[p] >= SRC_COUNT ||
                PAIR_PRI[p] == PAIR_SHD[p]) begin
                ok = 1'b0;
            end else begin
                if (seen[PAIR_PRI[p]] || seen[PAIR_SHD[p]]) ok = 1'b0;
                seen[PAIR_PRI[p]] = 1'b1;
                seen[PAIR_SHD[p]] = 1'b1;
            end
        end
        return ok;
    endfunction

    function automatic role_tab_t build_roles();
        role_tab_t r;
        for (int n = 0; n < SRC_COUNT; n++) r[n] = ROLE_PLAIN;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (PAIR_PRI[p] < SRC_COUNT && PAIR_SHD[p] < SRC_COUNT) begin
                r[PAIR_PRI[p]] = ROLE_PRIMARY;
                r[PAIR_SHD[p]] = ROLE_SHADOW;
            end
        end
        return r;
    endfunction

    function automatic idx_tab_t build_partner();
        idx_tab_t t;
        for (int n = 0; n < SRC_COUNT; n++) t[n] = n;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (PAIR_PRI[p] < SRC_COUNT && PAIR_SHD[p] < SRC_COUNT)
                t[PAIR_SHD[p]] = PAIR_PRI[p];
        end
        return t;
    endfunction

    function automatic src_vec_t role_set(input role_e which);
        role_tab_t r;
        src_vec_t  v;
        r = build_roles();
        for (int n = 0; n < SRC_COUNT; n++) v[n] = (r[n] == which);
        return v;
    endfunction

    localparam role_tab_t ROLES       = build_roles();
    localparam idx_tab_t  PARTNER     = build_partner();
    localparam src_vec_t  SHADOW_SET  = role_set(ROLE_SHADOW);
    localparam src_vec_t  PRIMARY_SET = role_set(ROLE_PRIMARY);
    localparam src_vec_t  PLAIN_SET   = role_set(ROLE_PLAIN);
    localparam src_vec_t  TO_VPE0     = PRIMARY_SET | (PLAIN_SET & ~ROUTE_VPE1);
    localparam src_vec_t  TO_VPE1     = SHADOW_SET  | (PLAIN_SET &  ROUTE_VPE1);

    if (!pairs_valid()) begin : g_bad_pairs
        $error("dvpe_irq_ctrl: shadow pairing parameters are inconsistent");
    end

    src_vec_t mask_vec;
    src_vec_t pend_next;
    src_vec_t pend_q;
    req_t     req_q;

    dvpe_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .pend      (pend_q),
        .mask      (mask_vec),
        .reg_rdata (reg_rdata)
    );

    dvpe_irq_gate #(
        .ROLES   (ROLES),
        .PARTNER (PARTNER),
        .SHD_SET (SHADOW_SET)
    ) u_gate (
        .irq_in    (irq_in),
        .mask      (mask_vec),
        .pend_next (pend_next)
    );

    dvpe_irq_deliver #(
        .TO_VPE0 (TO_VPE0),
        .TO_VPE1 (TO_VPE1)
    ) u_deliver (
        .clk       (clk),
        .rst       (rst),
        .pend_next (pend_next),
        .pend_q    (pend_q),
        .req_q     (req_q)
    );

    assign irq_vpe0 = req_q.vpe0;
    assign irq_vpe1 = req_q.vpe1;

endmodule

// File: rtl/dvpe_irq_ctrl_chk.sv
module dvpe_irq_ctrl_chk
    import dvpe_irq_pkg::*;
#(
    parameter src_vec_t SHD_SET = '0
)(
    input logic     clk,
    input logic     rst,
    input src_vec_t irq_in,
    input addr_t    reg_addr,
    input logic     reg_wen,
    input word_t    reg_rdata,
    input logic     irq_vpe0,
    input logic     irq_vpe1,
    input src_vec_t mask_vec
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_vpe0 && !irq_vpe1 && reg_rdata == '0));

    assert_hi_mask_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        $past(decode_addr(reg_addr) == SEL_MASK_HI) |-> reg_rdata[DATA_W-1:HI_COUNT] == '0);

    assert_all_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        $past(mask_vec == '0) |-> (!irq_vpe0 && !irq_vpe1));

    assert_shadow_wire_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        $past((irq_in & ~SHD_SET) == '0) |-> (!irq_vpe0 && !irq_vpe1));

    assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $past(decode_addr(reg_addr) == SEL_NONE) |-> reg_rdata == '0);

    assert_nonmask_write_inert_R8: assert property (@(posedge clk) disable iff (rst)
        $past(reg_wen && decode_addr(reg_addr) != SEL_MASK_LO &&
              decode_addr(reg_addr) != SEL_MASK_HI) |-> mask_vec == $past(mask_vec));

endmodule

bind dvpe_irq_ctrl dvpe_irq_ctrl_chk #(.SHD_SET(SHADOW_SET)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_rdata (reg_rdata),
    .irq_vpe0  (irq_vpe0),
    .irq_vpe1  (irq_vpe1),
    .mask_vec  (mask_vec)
);

// File: tb/dvpe_irq_ctrl_test.sv
module dvpe_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [31:0] m0;
        logic [7:0]  m1;
        logic [39:0] src;
        logic        e0;
        logic        e1;
    } vec_t;

    // mask_lo, mask_hi, inputs, expected irq_vpe0, expected irq_vpe1
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 8'h00, 40'hFF_FFFF_FFFF, 1'b0, 1'b0},
        '{32'h0000_0001, 8'h00, 40'h00_0000_0001, 1'b1, 1'b0},
        '{32'h0000_0200, 8'h00, 40'h00_0000_0200, 1'b0, 1'b1},
        '{32'h0000_0100, 8'h00, 40'h00_0000_0100, 1'b1, 1'b0},
        '{32'h0000_0008, 8'h00, 40'h00_0000_0100, 1'b0, 1'b1},
        '{32'h0000_0008, 8'h00, 40'h00_0000_0008, 1'b0, 1'b0},
        '{32'h0000_0108, 8'h00, 40'h00_0000_0100, 1'b1, 1'b1},
        '{32'h0000_0000, 8'h01, 40'h01_0000_0000, 1'b1, 1'b0},
        '{32'h0000_0000, 8'h80, 40'h80_0000_0000, 1'b0, 1'b1},
        '{32'h2000_0000, 8'h00, 40'h00_4000_0000, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 8'hFF, 40'h00_0000_0000, 1'b0, 1'b0},
        '{32'h4000_0000, 8'h00, 40'h00_2000_0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] irq_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_vpe0;
    logic        irq_vpe1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvpe_irq_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_vpe0  (irq_vpe0),
        .irq_vpe1  (irq_vpe1)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        tick();
        reg_wen   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        tick();
        d = reg_rdata;
    endtask

    // Pending per R3: shadow 3 follows line 8, shadow 29 follows line 30.
    function automatic logic [39:0] model_pend(input logic [39:0] m, input logic [39:0] s);
        logic [39:0] p;
        for (int n = 0; n < 40; n++) begin
            logic lvl;
            lvl = s[n];
            if (n == 3)  lvl = s[8];
            if (n == 29) lvl = s[30];
            p[n] = lvl & m[n];
        end
        return p;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;

        // R1: reset state
        check("R1 vpe0", {39'b0, irq_vpe0}, 40'h0);
        check("R1 vpe1", {39'b0, irq_vpe1}, 40'h0);
        check("R1 rdata", {8'h0, reg_rdata}, 40'h0);
        rd(8'h04, r); check("R1 mask_lo", {8'h0, r}, 40'h0);
        rd(8'h50, r); check("R1 mask_hi", {8'h0, r}, 40'h0);
        rd(8'h08, r); check("R1 pend_lo", {8'h0, r}, 40'h0);
        rd(8'h54, r); check("R1 pend_hi", {8'h0, r}, 40'h0);

        // Vector walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] exp_p;
            irq_in = '0;
            wr(8'h04, VECS[i].m0);
            wr(8'h50, {24'h0, VECS[i].m1});
            irq_in = VECS[i].src;
            tick();
            check($sformatf("R4/R5/R6/R7 vec%0d vpe0", i), {39'b0, irq_vpe0}, {39'b0, VECS[i].e0});
            check($sformatf("R4/R5/R6/R7 vec%0d vpe1", i), {39'b0, irq_vpe1}, {39'b0, VECS[i].e1});
            exp_p = model_pend({VECS[i].m1, VECS[i].m0}, VECS[i].src);
            rd(8'h08, r); check($sformatf("R3 vec%0d pend_lo", i), {8'h0, r}, {8'h0, exp_p[31:0]});
            rd(8'h54, r); check($sformatf("R3 vec%0d pend_hi", i), {8'h0, r}, {32'h0, exp_p[39:32]});
        end

        // R2: readback and high-register width
        irq_in = '0;
        wr(8'h04, 32'hA5A5_5A5A);
        rd(8'h04, r); check("R2 mask_lo readback", {8'h0, r}, 40'h00_A5A5_5A5A);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, r); check("R2 mask_hi upper zero", {8'h0, r}, 40'h00_0000_00FF);

        // R3: writes to pending ignored
        wr(8'h08, 32'h0000_0000);
        rd(8'h04, r); check("R3 pend write no effect mask_lo", {8'h0, r}, 40'h00_A5A5_5A5A);
        wr(8'h54, 32'h0000_0000);
        rd(8'h50, r); check("R3 pend write no effect mask_hi", {8'h0, r}, 40'h00_0000_00FF);

        // R8: unmapped offsets
        wr(8'h10, 32'h0000_0000);
        rd(8'h04, r); check("R8 unmapped write mask_lo", {8'h0, r}, 40'h00_A5A5_5A5A);
        rd(8'h00, r); check("R8 unmapped read 0x00", {8'h0, r}, 40'h0);
        rd(8'h0C, r); check("R8 unmapped read 0x0C", {8'h0, r}, 40'h0);

        // R9: mask-write latency of two edges
        wr(8'h04, 32'h0);
        wr(8'h50, 32'h0);
        irq_in = 40'h1;
        tick();
        check("R9 masked baseline", {39'b0, irq_vpe0}, 40'h0);
        reg_addr = 8'h04; reg_wdata = 32'h1; reg_wen = 1'b1;
        tick();
        reg_wen = 1'b0;
        check("R9 one edge after write", {39'b0, irq_vpe0}, 40'h0);
        tick();
        check("R9 two edges after write", {39'b0, irq_vpe0}, 40'h1);
        // R9: input-change latency of one edge
        irq_in = 40'h0;
        check("R9 before edge", {39'b0, irq_vpe0}, 40'h1);
        tick();
        check("R9 input drop one edge", {39'b0, irq_vpe0}, 40'h0);

        // R7: shadow wires 3 and 29 alone raise nothing, even fully unmasked
        wr(8'h04, 32'hFFFF_FFFF);
        irq_in = 40'h00_2000_0008;
        tick();
        check("R7 shadow wires vpe0", {39'b0, irq_vpe0}, 40'h0);
        check("R7 shadow wires vpe1", {39'b0, irq_vpe1}, 40'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule